// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block sits between a group of interrupting devices and a CPU. Each device drives a level-sensitive request line, and each line has a fixed priority: a higher line index wins. A separate non-maskable line ranks above every device line. After the lines pass through a synchronizer, the controller picks the highest active request. It offers that request to the CPU only if the request outranks the priority level now in service.

When the CPU acknowledges an offered device request, the controller pulses an acknowledge to the winning device and waits a bounded number of cycles for that device to return a vector. If the vector arrives in time, the controller emits it as a handler-table index, and the granted level becomes the new service level. The level it interrupted is saved on a nesting stack. If no vector arrives, the controller reports a bus error and the service level stays as it was. A non-maskable request is dispatched straight to a fixed vector, with no device fetch. An end-of-service pulse from the CPU restores the level that was interrupted. Requests that were held back while a higher level was in service are then offered again.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `cpu_irq`, `dev_ack`, `dispatch_valid` and `bus_err` are 0 and `cur_prio` is 0, where 0 means no interrupt is in service.
- R2: Device line i has priority level i+1. Among the active device lines, the highest index wins, and its index appears on `dev_ack_id` with the acknowledge pulse.
- R3: `cpu_irq` is raised only while the winning level is strictly above `cur_prio`. A request at or below `cur_prio` is held until end-of-service lowers `cur_prio`, and it is offered as soon as that happens.
- R4: The non-maskable line has level N_SRC+1 (9 by default) and is offered whenever `cur_prio` is below that level. Acknowledging it gives `dispatch_valid` with index `NMI_VECTOR` (default 8'hFF) in the next cycle. In that case `dev_ack` is not pulsed and no vector fetch takes place.
- R5: `cpu_ack` while `cpu_irq` is low and no fetch is in progress has no effect: no `dev_ack`, no dispatch, and no change to `cur_prio`.
- R6: An accepted device acknowledge pulses `dev_ack` for exactly one cycle in the cycle after the ack edge. `cpu_irq` stays low until the vector fetch ends.
- R7: A `vec_valid` sampled on any of the VEC_TIMEOUT (16) clock edges after the ack edge, including the last one, gives a one-cycle `dispatch_valid` with `dispatch_index` equal to `vec_data`. `cur_prio` becomes the granted level in that same cycle.
- R8: If no vector arrives within those 16 edges, `bus_err` pulses for one cycle right after the 16th edge. In that case there is no dispatch and `cur_prio` keeps its value.
- R9: An `eos` pulse returns `cur_prio` to the level that was interrupted, in last-in first-out order, through a full nest of all 8 device levels plus the non-maskable level. An `eos` when `cur_prio` is 0 is ignored.
- R10: A change on a request line reaches `cpu_irq` after exactly two clock edges.
- R11: `vec_valid` outside a vector fetch is ignored and produces no dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Level-sensitive device request lines |
| nmi_req | input | 1 | Level-sensitive non-maskable request |
| cpu_irq | output | 1 | Interrupt offered to the CPU |
| cpu_ack | input | 1 | CPU accepts the offered interrupt |
| eos | input | 1 | CPU end-of-service pulse |
| dev_ack | output | 1 | Acknowledge pulse to the winning device |
| dev_ack_id | output | clog2(N_SRC) | Index of the acknowledged device |
| vec_valid | input | 1 | Device vector present |
| vec_data | input | VEC_W | Device vector |
| dispatch_valid | output | 1 | Handler-table index valid (one cycle) |
| dispatch_index | output | VEC_W | Handler-table index |
| bus_err | output | 1 | Vector fetch timed out (one cycle) |
| cur_prio | output | clog2(N_SRC+2) | Priority level now in service |

## Verification
The bench goes after several corner cases. It checks the last legal vector edge, where a counter that is off by one would turn a valid vector into a bus error, or would accept one edge too many. It checks a request equal to the service level, which a design that compares with greater-or-equal would re-enter. It checks a non-maskable request taken during device service, where a design that fetches a vector for it, or lets it be masked, would stall. It checks a full nine-deep nest popped level by level, where a stack that is off by one would restore the wrong level. It also checks that a held lower request is offered on the exact cycle its masking service ends, and that an acknowledge or vector arriving outside its window leaves every output and `cur_prio` unchanged.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fetch_st_t;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
   parameter int N_SRC = 8,
   parameter int LW    = 4,
   parameter int IDW   = 3
) (
   input  logic [N_SRC-1:0] req,
   input  logic             nmi,
   output logic             valid,
   output logic [LW-1:0]    level,
   output logic [IDW-1:0]   id,
   output logic             is_nmi
);
   // Later (higher index) matches override earlier ones; NMI overrides all.
   always_comb begin
      valid  = 1'b0;
      level  = '0;
      id     = '0;
      is_nmi = 1'b0;
      for (int i = 0; i < N_SRC; i++) begin
         if (req[i]) begin
            valid = 1'b1;
            level = LW'(i + 1);
            id    = IDW'(i);
         end
      end
      if (nmi) begin
         valid  = 1'b1;
         level  = LW'(N_SRC + 1);
         id     = '0;
         is_nmi = 1'b1;
      end
   end
endmodule

// File: rtl/pvic_nest.sv
module pvic_nest #(
   parameter int DEPTH = 8,
   parameter int LW    = 4,
   parameter int DW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [LW-1:0] push_level,
   input  logic          pop,
   output logic [LW-1:0] cur_level,
   output logic [DW-1:0] depth
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [LW-1:0] mem [DEPTH];
   logic [LW-1:0] p_cur, n_cur;
   logic [DW-1:0] p_depth, n_depth;
   logic          wr_en;
   logic [AW-1:0] rd_idx, wr_idx;

   assign rd_idx = AW'(depth - 1'b1);
   assign wr_idx = AW'(p_depth);

   // Pop first, then push on top of the popped state.
   always_comb begin
      p_cur   = cur_level;
      p_depth = depth;
      if (pop && cur_level != '0) begin
         if (depth != '0) begin
            p_cur   = mem[rd_idx];
            p_depth = depth - 1'b1;
         end else begin
            p_cur = '0;
         end
      end
      n_cur   = p_cur;
      n_depth = p_depth;
      wr_en   = 1'b0;
      if (push) begin
         n_cur = push_level;
         if (p_cur != '0) begin
            wr_en   = 1'b1;
            n_depth = p_depth + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_level <= '0;
         depth     <= '0;
      end else begin
         cur_level <= n_cur;
         depth     <= n_depth;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= p_cur;
   end
endmodule

// File: rtl/pvic_fetch.sv
module pvic_fetch
   import pvic_pkg::*;
#(
   parameter int              IDW     = 3,
   parameter int              LW      = 4,
   parameter int              VEC_W   = 8,
   parameter int              TMO     = 16,
   parameter logic [VEC_W-1:0] NMI_VEC = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             offer,
   input  logic             cpu_ack,
   input  logic [LW-1:0]    win_level,
   input  logic [IDW-1:0]   win_id,
   input  logic             win_is_nmi,
   input  logic             vec_valid,
   input  logic [VEC_W-1:0] vec_data,
   output logic             busy,
   output logic             commit,
   output logic [LW-1:0]    commit_level,
   output logic             dev_ack,
   output logic [IDW-1:0]   dev_ack_id,
   output logic             dispatch_valid,
   output logic [VEC_W-1:0] dispatch_index,
   output logic             bus_err
);
   localparam int CW = (TMO > 1) ? $clog2(TMO) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(TMO - 1);

   fetch_st_t     st;
   logic [CW-1:0] cnt;
   logic [LW-1:0] held_level;
   logic          take;

   assign take = offer && cpu_ack;
   assign busy = (st == FS_WAIT);

   always_comb begin
      commit       = 1'b0;
      commit_level = held_level;
      if (st == FS_IDLE && take && win_is_nmi) begin
         commit       = 1'b1;
         commit_level = win_level;
      end else if (st == FS_WAIT && vec_valid) begin
         commit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= FS_IDLE;
         cnt            <= '0;
         held_level     <= '0;
         dev_ack        <= 1'b0;
         dev_ack_id     <= '0;
         dispatch_valid <= 1'b0;
         dispatch_index <= '0;
         bus_err        <= 1'b0;
      end else begin
         dev_ack        <= 1'b0;
         dispatch_valid <= 1'b0;
         bus_err        <= 1'b0;
         unique case (st)
            FS_IDLE: begin
               if (take) begin
                  if (win_is_nmi) begin
                     dispatch_valid <= 1'b1;
                     dispatch_index <= NMI_VEC;
                  end else begin
                     st         <= FS_WAIT;
                     cnt        <= '0;
                     held_level <= win_level;
                     dev_ack    <= 1'b1;
                     dev_ack_id <= win_id;
                  end
               end
            end
            FS_WAIT: begin
               if (vec_valid) begin
                  dispatch_valid <= 1'b1;
                  dispatch_index <= vec_data;
                  st             <= FS_IDLE;
               end else if (cnt == CNT_LAST) begin
                  bus_err <= 1'b1;
                  st      <= FS_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
   parameter int               N_SRC       = 8,
   parameter int               NEST_DEPTH  = 8,
   parameter int               VEC_W       = 8,
   parameter int               VEC_TIMEOUT = 16,
   parameter int               SYNC_STAGES = 2,
   parameter logic [VEC_W-1:0] NMI_VECTOR  = '1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_SRC-1:0]              irq_req,
   input  logic                          nmi_req,
   output logic                          cpu_irq,
   input  logic                          cpu_ack,
   input  logic                          eos,
   output logic                          dev_ack,
   output logic [$clog2(N_SRC)-1:0]      dev_ack_id,
   input  logic                          vec_valid,
   input  logic [VEC_W-1:0]              vec_data,
   output logic                          dispatch_valid,
   output logic [VEC_W-1:0]              dispatch_index,
   output logic                          bus_err,
   output logic [$clog2(N_SRC+2)-1:0]    cur_prio
);
   localparam int IDW = $clog2(N_SRC);
   localparam int LW  = $clog2(N_SRC + 2);
   localparam int DW  = $clog2(NEST_DEPTH + 1);

   generate
      if (N_SRC < 2) begin : g_bad_nsrc
         $error("prio_vec_intc: N_SRC must be at least 2");
      end
      if (NEST_DEPTH < N_SRC) begin : g_bad_depth
         $error("prio_vec_intc: NEST_DEPTH must cover every device level");
      end
      if (VEC_TIMEOUT < 2) begin : g_bad_tmo
         $error("prio_vec_intc: VEC_TIMEOUT must be at least 2");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("prio_vec_intc: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [N_SRC-1:0] irq_s;
   logic             nmi_s;
   logic             win_valid, win_is_nmi;
   logic [LW-1:0]    win_level;
   logic [IDW-1:0]   win_id;
   logic             busy, commit;
   logic [LW-1:0]    commit_level;
   logic [DW-1:0]    nest_depth;

   pvic_sync #(.W(N_SRC + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({nmi_req, irq_req}),
      .q     ({nmi_s, irq_s})
   );

   pvic_arb #(.N_SRC(N_SRC), .LW(LW), .IDW(IDW)) u_arb (
      .req    (irq_s),
      .nmi    (nmi_s),
      .valid  (win_valid),
      .level  (win_level),
      .id     (win_id),
      .is_nmi (win_is_nmi)
   );

   assign cpu_irq = win_valid && (win_level > cur_prio) && !busy;

   pvic_fetch #(
      .IDW(IDW), .LW(LW), .VEC_W(VEC_W), .TMO(VEC_TIMEOUT), .NMI_VEC(NMI_VECTOR)
   ) u_fetch (
      .clk            (clk),
      .rst_n          (rst_n),
      .offer          (cpu_irq),
      .cpu_ack        (cpu_ack),
      .win_level      (win_level),
      .win_id         (win_id),
      .win_is_nmi     (win_is_nmi),
      .vec_valid      (vec_valid),
      .vec_data       (vec_data),
      .busy           (busy),
      .commit         (commit),
      .commit_level   (commit_level),
      .dev_ack        (dev_ack),
      .dev_ack_id     (dev_ack_id),
      .dispatch_valid (dispatch_valid),
      .dispatch_index (dispatch_index),
      .bus_err        (bus_err)
   );

   pvic_nest #(.DEPTH(NEST_DEPTH), .LW(LW), .DW(DW)) u_nest (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (commit),
      .push_level (commit_level),
      .pop        (eos),
      .cur_level  (cur_prio),
      .depth      (nest_depth)
   );
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk #(
   parameter int N_SRC = 8,
   parameter int LW    = 4,
   parameter int DW    = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_irq,
   input logic          cpu_ack,
   input logic          eos,
   input logic          dev_ack,
   input logic          dispatch_valid,
   input logic          bus_err,
   input logic [LW-1:0] cur_prio,
   input logic          busy,
   input logic [DW-1:0] depth,
   input logic          nmi_s
);
   localparam logic [LW-1:0] NMI_LVL = LW'(N_SRC + 1);

   // R3: every dispatch raises the service level
   p_dispatch_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_valid |-> cur_prio > $past(cur_prio));

   // R4: a synchronized NMI below its own level is always offered when idle
   p_nmi_offered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_s && (cur_prio < NMI_LVL) && !busy |-> cpu_irq);

   // R5: an ack that was not offered does nothing
   p_ack_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack && !cpu_irq && !busy |=> !dev_ack && !dispatch_valid);

   // R6: device ack is a single-cycle pulse and masks further offers
   p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);
   p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> !cpu_irq);

   // R8: a timeout never dispatches and leaves the service level alone
   p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(dispatch_valid && bus_err));
   p_err_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err && !$past(eos) |-> cur_prio == $past(cur_prio));

   // R9: nesting never exceeds the number of device levels
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= DW'(N_SRC));
endmodule

bind prio_vec_intc prio_vec_intc_chk #(
   .N_SRC(N_SRC), .LW($clog2(N_SRC + 2)), .DW($clog2(NEST_DEPTH + 1))
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cpu_irq        (cpu_irq),
   .cpu_ack        (cpu_ack),
   .eos            (eos),
   .dev_ack        (dev_ack),
   .dispatch_valid (dispatch_valid),
   .bus_err        (bus_err),
   .cur_prio       (cur_prio),
   .busy           (busy),
   .depth          (nest_depth),
   .nmi_s          (nmi_s)
);

// File: tb/tb_prio_vec_intc.sv
`timescale 1ns/1ps
module tb_prio_vec_intc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_req = '0;
   logic       nmi_req = 1'b0;
   logic       cpu_irq;
   logic       cpu_ack = 1'b0;
   logic       eos = 1'b0;
   logic       dev_ack;
   logic [2:0] dev_ack_id;
   logic       vec_valid = 1'b0;
   logic [7:0] vec_data = '0;
   logic       dispatch_valid;
   logic [7:0] dispatch_index;
   logic       bus_err;
   logic [3:0] cur_prio;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   prio_vec_intc dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
      .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .eos(eos), .dev_ack(dev_ack),
      .dev_ack_id(dev_ack_id), .vec_valid(vec_valid), .vec_data(vec_data),
      .dispatch_valid(dispatch_valid), .dispatch_index(dispatch_index),
      .bus_err(bus_err), .cur_prio(cur_prio)
   );

   // {request mask, expected winner index, vector to return}
   localparam logic [23:0] TBL [6] = '{
      {8'b0000_0001, 8'd0, 8'h10},
      {8'b1000_0000, 8'd7, 8'h11},
      {8'b0010_0110, 8'd5, 8'h12},
      {8'b0101_0101, 8'd6, 8'h13},
      {8'b0000_1100, 8'd3, 8'h14},
      {8'b1111_1111, 8'd7, 8'h15}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_req(input logic [7:0] m);
      irq_req = m;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_ack();
      cpu_ack = 1'b1;
      @(negedge clk);
      cpu_ack = 1'b0;
   endtask

   task automatic give_vec(input logic [7:0] v);
      vec_valid = 1'b1;
      vec_data  = v;
      @(negedge clk);
      vec_valid = 1'b0;
   endtask

   task automatic end_svc();
      eos = 1'b1;
      @(negedge clk);
      eos = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 cur_prio in reset", int'(cur_prio), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cpu_irq", int'(cpu_irq), 0);
      chk("R1 dev_ack", int'(dev_ack), 0);
      chk("R1 dispatch_valid", int'(dispatch_valid), 0);
      chk("R1 bus_err", int'(bus_err), 0);
      chk("R1 cur_prio", int'(cur_prio), 0);

      // table walk: R2 R3 R6 R7 R9
      for (int k = 0; k < 6; k++) begin
         set_req(TBL[k][23:16]);
         chk("R3 offer when idle", int'(cpu_irq), 1);
         pulse_ack();
         chk("R6 dev_ack pulse", int'(dev_ack), 1);
         chk("R2 winner id", int'(dev_ack_id), int'(TBL[k][15:8]));
         chk("R6 cpu_irq low in fetch", int'(cpu_irq), 0);
         give_vec(TBL[k][7:0]);
         chk("R7 dispatch_valid", int'(dispatch_valid), 1);
         chk("R7 dispatch_index", int'(dispatch_index), int'(TBL[k][7:0]));
         chk("R7 cur_prio level", int'(cur_prio), int'(TBL[k][15:8]) + 1);
         irq_req = '0;
         @(negedge clk);
         chk("R7 dispatch one cycle", int'(dispatch_valid), 0);
         end_svc();
         chk("R9 pop to idle", int'(cur_prio), 0);
         repeat (2) @(negedge clk);
      end

      // R10: two-edge synchronizer
      irq_req = 8'h04;
      @(negedge clk);
      chk("R10 not yet after one edge", int'(cpu_irq), 0);
      @(negedge clk);
      chk("R10 visible after two edges", int'(cpu_irq), 1);
      set_req(8'h00);

      // R5: ack with nothing offered
      pulse_ack();
      chk("R5 no dev_ack", int'(dev_ack), 0);
      chk("R5 no dispatch", int'(dispatch_valid), 0);
      @(negedge clk);
      chk("R5 cur_prio unchanged", int'(cur_prio), 0);

      // R11: stray vector
      give_vec(8'h77);
      chk("R11 stray vector ignored", int'(dispatch_valid), 0);
      // R9: eos when idle
      end_svc();
      chk("R9 eos at idle ignored", int'(cur_prio), 0);

      // nesting with held lower request and NMI
      set_req(8'h08);
      pulse_ack();
      give_vec(8'h30);
      chk("R7 nest level 4", int'(cur_prio), 4);
      set_req(8'h09);
      chk("R3 lower request held", int'(cpu_irq), 0);
      set_req(8'h49);
      chk("R3 higher request offered", int'(cpu_irq), 1);
      pulse_ack();
      chk("R2 nested winner", int'(dev_ack_id), 6);
      give_vec(8'h36);
      chk("R7 nest level 7", int'(cur_prio), 7);
      nmi_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R4 nmi offered over level 7", int'(cpu_irq), 1);
      pulse_ack();
      chk("R4 nmi no dev_ack", int'(dev_ack), 0);
      chk("R4 nmi dispatch", int'(dispatch_valid), 1);
      chk("R4 nmi vector", int'(dispatch_index), 8'hFF);
      chk("R4 nmi level", int'(cur_prio), 9);
      chk("R4 nmi not re-entered", int'(cpu_irq), 0);
      nmi_req = 1'b0;
      set_req(8'h09);
      end_svc();
      chk("R9 back to 7", int'(cur_prio), 7);
      end_svc();
      chk("R9 back to 4", int'(cur_prio), 4);
      chk("R3 equal level held", int'(cpu_irq), 0);
      set_req(8'h01);
      end_svc();
      chk("R9 back to idle", int'(cur_prio), 0);
      chk("R3 held request offered at once", int'(cpu_irq), 1);
      pulse_ack();
      give_vec(8'h01);
      chk("R7 level 1", int'(cur_prio), 1);
      set_req(8'h00);
      end_svc();

      // R9: full nest of 8 device levels plus NMI
      for (int i = 0; i < 8; i++) begin
         set_req(8'((16'h1 << (i + 1)) - 1));
         pulse_ack();
         give_vec(8'(8'h40 + i));
         chk("R9 push level", int'(cur_prio), i + 1);
      end
      nmi_req = 1'b1;
      repeat (3) @(negedge clk);
      pulse_ack();
      chk("R4 nmi over full nest", int'(cur_prio), 9);
      nmi_req = 1'b0;
      set_req(8'h00);
      for (int lvl = 8; lvl >= 0; lvl--) begin
         end_svc();
         chk("R9 LIFO restore", int'(cur_prio), lvl);
      end

      // R8: timeout
      set_req(8'h10);
      pulse_ack();
      for (int c = 1; c <= 15; c++) begin
         @(negedge clk);
         chk("R8 no early bus_err", int'(bus_err), 0);
      end
      @(negedge clk);
      chk("R8 bus_err after 16 edges", int'(bus_err), 1);
      chk("R8 no dispatch on timeout", int'(dispatch_valid), 0);
      chk("R8 cur_prio kept", int'(cur_prio), 0);
      @(negedge clk);
      chk("R8 bus_err one cycle", int'(bus_err), 0);
      chk("R8 request re-offered", int'(cpu_irq), 1);

      // R7: vector on the last legal edge
      pulse_ack();
      repeat (15) @(negedge clk);
      give_vec(8'h5A);
      chk("R7 last-edge dispatch", int'(dispatch_valid), 1);
      chk("R7 last-edge index", int'(dispatch_index), 8'h5A);
      chk("R7 last-edge no bus_err", int'(bus_err), 0);
      chk("R7 last-edge level", int'(cur_prio), 5);
      set_req(8'h00);
      end_svc();
      chk("R9 final idle", int'(cur_prio), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule